// File: doc/BRIEF.md
# Quadrature Encoder Counter Channel

This block is one 24-bit counter channel with a 16-bit register port. It counts the two phase signals of an incremental encoder at one, two or four counts per encoder cycle, or counts the system clock with the direction set by software. A 16-bit mode word holds all configuration: count source and resolution, direction source, enable source, automatic reload, output source and polarity, read latching, and which of two preload registers the data port writes.

Command bits in a control word reset the counter, load it from the first preload register, and clear a capture flag. The flag is set whenever the count passes through zero in either direction. An index input can reload the counter, and a wrap can reload it from the second preload register. A single output pin shows either the capture flag or a count-equals-zero flag, with selectable polarity.

The port has four word addresses: 0 is the low data word, 1 is the high data word, 2 is the mode word, and 3 is the control word. Read data appears on `bus_rdata` one clock after the read strobe.

Top module: `qenc_counter_chan`

## Requirements
- R1: After reset the count, both preload registers, the mode word and the capture flag are zero. Reads of the data words return 0 and `cnt_out` is 0.
- R2: A read of address 0 returns count bits 15:0. A read of address 1 returns count bits 23:16 in bits 7:0, with bits 15:8 zero. A read of address 2 returns the mode word. When mode bit 13 is 0, the count is latched by the address-0 read, and the next address-1 read returns the upper byte of that same sample. When bit 13 is 1, both words show the live count.
- R3: Mode bits 10:9 select the count source: 0 is x1, 1 is x2, 3 is x4 and 2 is the internal clock. The encoder state {A,B} moving forward through 00, 01, 11, 10 counts up. In x4, every legal phase change counts. In x2, only changes of A count. In x1, a rise of A counts forward and a fall of A counts backward.
- R4: An encoder change in which A and B both toggle at once leaves the count unchanged.
- R5: When mode bit 12 is 0, the direction comes from the encoder phase. When bit 12 is 1, mode bit 11 sets it: 0 counts up and 1 counts down.
- R6: With the internal clock source, the count moves by one on every enabled clock cycle.
- R7: Mode bits 8:7 control enabling: 0 holds the count and 1 always enables. Values 2 and 3 use the hardware source in bits 6:5: 0 always enables, 1 enables while the index input is high, and 2 or 3 enables while the capture flag is low.
- R8: Writing the control word with bit 15 set clears the count, and bit 15 wins over bit 14. Bit 14 loads the count from preload register 0. Bit 3 clears the capture flag.
- R9: Writes to address 0 set bits 15:0 and writes to address 1 set bits 23:16 (from data bits 7:0) of a preload register. Mode bit 14 chooses register 1 when set and register 0 when clear.
- R10: Mode bits 4:2 select automatic reload. With value 4, a rising edge of the index input loads preload register 0. With value 1, a wrap through zero loads preload register 1 instead of wrapping. Other values reload nothing.
- R11: The capture flag is set when the count wraps from all ones to zero or from zero to all ones. `cnt_out` is the capture flag when mode bit 0 is 0, or count-equals-zero when it is 1, exclusive-ORed with mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index, asynchronous |
| cnt_out | output | 1 | Selected counter output |

## Verification
The encoder is walked through whole phase cycles at each resolution in both directions, starting from a fixed phase. This separates x1, x2 and x4 by the count they reach, and shows wraps below zero as negative values.

A run with a software-forced direction against forward phase motion shows that the direction source is selected correctly. A jump that toggles both phases together must leave the count alone.

The internal clock is gated by index windows of a known length, so the count equals the window length. This also drives a wrap that sets the capture flag, which then stalls counting under the inverted-flag enable.

Reads taken across a count change show whether the high word comes from the latched sample or from the live count.

// File: rtl/qcc_pkg.sv
package qcc_pkg;
  typedef struct packed {
    logic       rsvd;
    logic       pr_sel;
    logic       latch_live;
    logic       dir_sw_en;
    logic       dir_sw_down;
    logic [1:0] clk_src;
    logic [1:0] en_ctl;
    logic [1:0] hw_en_src;
    logic [2:0] auto_sel;
    logic       out_pol;
    logic       out_src;
  } mode_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  localparam logic [1:0] SRC_X1  = 2'd0;
  localparam logic [1:0] SRC_X2  = 2'd1;
  localparam logic [1:0] SRC_INT = 2'd2;
  localparam logic [1:0] SRC_X4  = 2'd3;

  localparam logic [2:0] AUTO_WRAP_PR1 = 3'd1;
  localparam logic [2:0] AUTO_IDX_PR0  = 3'd4;
endpackage

// File: rtl/qcc_quad_decode.sv
module qcc_quad_decode
  import qcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_idx,
  input  logic [1:0] clk_src,
  output logic       step,
  output logic       q_up,
  output logic       idx_lvl,
  output logic       idx_rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] a_sh, b_sh, i_sh;
  logic a_cur, a_prv, b_cur, b_prv;
  logic [1:0] pos_cur, pos_prv, delta;
  logic fwd, bwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
      i_sh <= '0;
    end else begin
      a_sh <= {a_sh[SH_W-2:0], enc_a};
      b_sh <= {b_sh[SH_W-2:0], enc_b};
      i_sh <= {i_sh[SH_W-2:0], enc_idx};
    end
  end

  always_comb begin
    a_cur    = a_sh[SH_W-2];
    a_prv    = a_sh[SH_W-1];
    b_cur    = b_sh[SH_W-2];
    b_prv    = b_sh[SH_W-1];
    pos_cur  = {a_cur, a_cur ^ b_cur};
    pos_prv  = {a_prv, a_prv ^ b_prv};
    delta    = pos_cur - pos_prv;
    fwd      = (delta == 2'd1);
    bwd      = (delta == 2'd3);
    idx_lvl  = i_sh[SH_W-2];
    idx_rise = i_sh[SH_W-2] & ~i_sh[SH_W-1];
    q_up     = fwd;
    case (clk_src)
      SRC_X4:  step = fwd | bwd;
      SRC_X2:  step = (fwd | bwd) & (a_cur ^ a_prv);
      SRC_INT: begin
        step = 1'b1;
        q_up = 1'b1;
      end
      default: step = (fwd & a_cur & ~a_prv) | (bwd & ~a_cur & a_prv);
    endcase
  end

  // R4
  illegal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && clk_src != SRC_INT) |-> ($countones({a_cur ^ a_prv, b_cur ^ b_prv}) == 1));
endmodule

// File: rtl/qcc_count_core.sv
module qcc_count_core
  import qcc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             q_up,
  input  logic             idx_lvl,
  input  logic             idx_rise,
  input  logic             dir_sw_en,
  input  logic             dir_sw_down,
  input  logic [1:0]       en_ctl,
  input  logic [1:0]       hw_en_src,
  input  logic [2:0]       auto_sel,
  input  logic             pr_sel,
  input  logic             pr_wr_lo,
  input  logic             pr_wr_hi,
  input  logic [BUS_W-1:0] wdata,
  input  logic             cmd_rst,
  input  logic             cmd_load,
  input  logic             cmd_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             rcap
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pr_q [2];
  logic [CNT_W-1:0] pr_d [2];
  logic rcap_q, rcap_d;
  logic en, up, adv, wrap;

  always_comb begin
    case (en_ctl)
      2'd0:    en = 1'b0;
      2'd1:    en = 1'b1;
      default: case (hw_en_src)
                 2'd0:    en = 1'b1;
                 2'd1:    en = idx_lvl;
                 default: en = ~rcap_q;
               endcase
    endcase
    up   = dir_sw_en ? ~dir_sw_down : q_up;
    adv  = step & en;
    wrap = adv & (up ? (cnt_q == {CNT_W{1'b1}}) : (cnt_q == '0));

    if (cmd_rst)                                   cnt_d = '0;
    else if (cmd_load)                             cnt_d = pr_q[0];
    else if (auto_sel == AUTO_IDX_PR0 && idx_rise) cnt_d = pr_q[0];
    else if (auto_sel == AUTO_WRAP_PR1 && wrap)    cnt_d = pr_q[1];
    else if (adv)                                  cnt_d = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    else                                           cnt_d = cnt_q;

    rcap_d = wrap ? 1'b1 : (cmd_clr ? 1'b0 : rcap_q);
  end

  for (genvar g = 0; g < 2; g++) begin : g_pr
    always_comb begin
      pr_d[g] = pr_q[g];
      if (pr_sel == g[0]) begin
        if (pr_wr_lo) pr_d[g][BUS_W-1:0]     = wdata;
        if (pr_wr_hi) pr_d[g][CNT_W-1:BUS_W] = wdata[HI_W-1:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pr_q[g] <= '0;
      else        pr_q[g] <= pr_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rcap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rcap_q <= rcap_d;
    end
  end

  assign cnt  = cnt_q;
  assign rcap = rcap_q;

  // R8
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (cnt_q == '0));
  // R8
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_rst) |=> (cnt_q == $past(pr_q[0])));
  // R11
  rcap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcap_q) |-> $past(wrap));
  // R8
  rcap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !wrap) |=> !rcap_q);
  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_rst || cmd_load || idx_rise || wrap) |=>
      ((cnt_q - $past(cnt_q)) == CNT_W'(0) || (cnt_q - $past(cnt_q)) == CNT_W'(1) ||
       (cnt_q - $past(cnt_q)) == {CNT_W{1'b1}}));
endmodule

// File: rtl/qenc_counter_chan.sv
module qenc_counter_chan
  import qcc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        enc_a,
  input  logic        enc_b,
  input  logic        enc_idx,
  output logic        cnt_out
);
  localparam int HI_W = CNT_W - BUS_W;

  logic [1:0] rst_sh;
  logic rst_ni;
  mode_t mode_q, mode_d;
  logic [CNT_W-1:0] cnt, latch_q, latch_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic rcap, step, q_up, idx_lvl, idx_rise;
  logic wr_lo, wr_hi, wr_ctl, rd_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ni = rst_sh[1];

  always_comb begin
    wr_lo  = bus_wr && bus_addr == ADDR_LO;
    wr_hi  = bus_wr && bus_addr == ADDR_HI;
    wr_ctl = bus_wr && bus_addr == ADDR_CTL;
    rd_lo  = bus_rd && bus_addr == ADDR_LO;
    mode_d = (bus_wr && bus_addr == ADDR_MODE) ? mode_t'(bus_wdata) : mode_q;
    latch_d = (mode_q.latch_live || rd_lo) ? cnt : latch_q;
    rdata_d = rdata_q;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_LO:   rdata_d = cnt[BUS_W-1:0];
        ADDR_HI:   rdata_d = BUS_W'(mode_q.latch_live ? cnt[CNT_W-1:BUS_W]
                                                       : latch_q[CNT_W-1:BUS_W]);
        ADDR_MODE: rdata_d = mode_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      latch_q <= '0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      latch_q <= latch_d;
      rdata_q <= rdata_d;
    end
  end

  qcc_quad_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_ni), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .clk_src(mode_q.clk_src), .step(step), .q_up(q_up),
    .idx_lvl(idx_lvl), .idx_rise(idx_rise)
  );

  qcc_count_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_core (
    .clk(clk), .rst_n(rst_ni), .step(step), .q_up(q_up),
    .idx_lvl(idx_lvl), .idx_rise(idx_rise),
    .dir_sw_en(mode_q.dir_sw_en), .dir_sw_down(mode_q.dir_sw_down),
    .en_ctl(mode_q.en_ctl), .hw_en_src(mode_q.hw_en_src), .auto_sel(mode_q.auto_sel),
    .pr_sel(mode_q.pr_sel), .pr_wr_lo(wr_lo), .pr_wr_hi(wr_hi), .wdata(bus_wdata),
    .cmd_rst(wr_ctl & bus_wdata[15]), .cmd_load(wr_ctl & bus_wdata[14]),
    .cmd_clr(wr_ctl & bus_wdata[3]), .cnt(cnt), .rcap(rcap)
  );

  assign bus_rdata = rdata_q;
  assign cnt_out   = (mode_q.out_src ? (cnt == '0) : rcap) ^ mode_q.out_pol;

  // R2
  read_latch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_lo && !mode_q.latch_live) |=> (latch_q == $past(cnt)));
  // R2
  hi_word_pad_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_rd && bus_addr == ADDR_HI) |=> (bus_rdata[BUS_W-1:HI_W] == '0));
endmodule

// File: tb/qenc_counter_chan_tb.sv
`timescale 1ns/1ps
module qenc_counter_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic cnt_out;
  int checks = 0;
  int errors = 0;
  int qpos = 0;

  always #2.5 clk = ~clk;

  qenc_counter_chan u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .cnt_out(cnt_out)
  );

  // mode[48:33] steps[32:25] forward[24] expected[23:0]
  localparam logic [48:0] VEC [7] = '{
    {16'h0680, 8'd8,  1'b1, 24'h000008},
    {16'h0280, 8'd8,  1'b1, 24'h000004},
    {16'h0080, 8'd8,  1'b1, 24'h000002},
    {16'h0680, 8'd4,  1'b0, 24'hFFFFFC},
    {16'h0280, 8'd12, 1'b0, 24'hFFFFFA},
    {16'h0080, 8'd8,  1'b0, 24'hFFFFFE},
    {16'h1E80, 8'd4,  1'b1, 24'hFFFFFC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [23:0] c);
    logic [15:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    c = {hi[7:0], lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qstep(input bit fwd);
    @(negedge clk);
    qpos = fwd ? (qpos + 1) % 4 : (qpos + 3) % 4;
    enc_a = qpos[1];
    enc_b = qpos[1] ^ qpos[0];
    idle(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] c;
    logic [15:0] w;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd_cnt(c);
    chk("R1 count", 32'(c), 32'h0);
    chk("R1 cnt_out", 32'(cnt_out), 32'h0);
    rd(2'd2, w);
    chk("R1 mode", 32'(w), 32'h0);

    // R3 R5 resolution and direction table
    for (int i = 0; i < 7; i++) begin
      wr(2'd2, VEC[i][48:33]);
      wr(2'd3, 16'h8008);
      for (int s = 0; s < int'(VEC[i][32:25]); s++) qstep(VEC[i][24]);
      rd_cnt(c);
      chk($sformatf("R3/R5 vector %0d", i), 32'(c), 32'(VEC[i][23:0]));
    end

    // R4 both phases toggle together
    wr(2'd2, 16'h0680);
    wr(2'd3, 16'h8000);
    @(negedge clk); enc_a = 1'b1; enc_b = 1'b1; idle(5);
    @(negedge clk); enc_a = 1'b0; enc_b = 1'b0; idle(5);
    rd_cnt(c);
    chk("R4 illegal ignored", 32'(c), 32'h0);

    // R9 R8 preload write and load; R2 latch coherency
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0012);
    wr(2'd3, 16'h4000);
    rd(2'd0, w);
    chk("R2 low word", 32'(w), 32'hFFFF);
    qstep(1'b1);
    rd(2'd1, w);
    chk("R2 latched high word", 32'(w), 32'h0012);
    rd_cnt(c);
    chk("R9/R8 load then count", 32'(c), 32'h130000);
    for (int s = 0; s < 3; s++) qstep(1'b1);
    // R2 live mode: bit 13
    wr(2'd2, 16'h2680);
    rd(2'd0, w);
    wr(2'd3, 16'h8000);
    rd(2'd1, w);
    chk("R2 live high word", 32'(w), 32'h0);

    // R8 reset wins over load
    wr(2'd2, 16'h0680);
    wr(2'd3, 16'h4000);
    wr(2'd3, 16'hC000);
    rd_cnt(c);
    chk("R8 reset priority", 32'(c), 32'h0);

    // R7 disabled holds
    wr(2'd2, 16'h0600);
    for (int s = 0; s < 4; s++) qstep(1'b1);
    rd_cnt(c);
    chk("R7 disabled", 32'(c), 32'h0);

    // R6 R7 internal clock gated by index window, up
    wr(2'd2, 16'h1520);
    @(negedge clk); enc_idx = 1'b1; idle(4);
    @(negedge clk); enc_idx = 1'b0; idle(5);
    rd_cnt(c);
    chk("R6 index window up", 32'(c), 32'h5);

    // R11 down through zero sets capture flag
    wr(2'd3, 16'h8000);
    wr(2'd2, 16'h1D20);
    @(negedge clk); enc_idx = 1'b1; idle(4);
    @(negedge clk); enc_idx = 1'b0; idle(5);
    rd_cnt(c);
    chk("R6 index window down", 32'(c), 32'hFFFFFB);
    chk("R11 capture out", 32'(cnt_out), 32'h1);

    // R7 inverted capture enable stalls
    wr(2'd2, 16'h1D40);
    idle(10);
    rd_cnt(c);
    chk("R7 stalled by flag", 32'(c), 32'hFFFFFB);
    rd(2'd2, w);
    chk("R2 mode readback", 32'(w), 32'h1D40);

    // R11 polarity, R8 clear, zero source
    wr(2'd2, 16'h0002);
    chk("R11 inverted out", 32'(cnt_out), 32'h0);
    wr(2'd3, 16'h0008);
    chk("R8 flag cleared", 32'(cnt_out), 32'h1);
    wr(2'd2, 16'h0001);
    chk("R11 zero src nonzero", 32'(cnt_out), 32'h0);
    wr(2'd3, 16'h8000);
    chk("R11 zero src zero", 32'(cnt_out), 32'h1);

    // R10 index reload from preload 0
    wr(2'd0, 16'h0100);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0690);
    wr(2'd3, 16'h8000);
    @(negedge clk); enc_idx = 1'b1; idle(4);
    @(negedge clk); enc_idx = 1'b0; idle(5);
    rd_cnt(c);
    chk("R10 index reload", 32'(c), 32'h100);

    // R10 R9 wrap reload from preload 1
    wr(2'd2, 16'h4684);
    wr(2'd0, 16'h0050);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h8000);
    qstep(1'b0);
    rd_cnt(c);
    chk("R10 wrap reload PR1", 32'(c), 32'h50);
    wr(2'd3, 16'h4000);
    rd_cnt(c);
    chk("R9 PR0 untouched", 32'(c), 32'h100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule